// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block produces the raster timing signals for a progressive video frame: horizontal sync and blank, vertical sync and blank, active video, active chroma, and a bank of sixteen frame-sync strobes that each fire once per frame. Its timing comes from a cycle counter that runs across each line and a line counter that runs down the frame. The extents of both counters, and every edge position, are programmable.

Software loads the timing through a simple write port into a shadow register set. It then pulses an update request. The shadow set is copied to the working set at the next frame start, so a frame never mixes old and new timing. Each timing output has its own polarity bit. Chroma gating supports full-rate chroma and alternate-line chroma, with optional even-pixel decimation.

Top module: `vid_timing_gen`

## Requirements
- R1: While `gen_en` is low, the counters hold at cycle 0, line 0. Every polarity-controlled output sits at its inactive level, which is the inverse of its polarity bit. All `fsync` bits are low. After reset all polarity bits are 0, so these outputs are high.
- R2: The first clock edge with `gen_en` high places the counters at (line 0, cycle 0). The cycle index counts 0 to Htotal-1 and then wraps. The line index advances on each cycle wrap and returns to 0 after Vtotal-1. Outputs are combinational decodes of the counters and have no extra latency.
- R3: `active_video` is active when cycle < Hactive and line < Vactive. `hblank` is active when cycle >= Hactive.
- R4: `hsync` is active for cycles in the range [Hsync start, Hsync end) on every line.
- R5: `vsync` becomes active at (Vsync start line, Vsync start cycle) and becomes inactive at (Vsync end line, Vsync end cycle), in raster order.
- R6: `vblank` becomes active at (line Vactive, cycle Vblank start) and stays active to the end of the frame. It is also active on line 0 for cycles below Vblank end.
- R7: Polarity word, at address 7: bit0 vblank, bit1 hblank, bit2 vsync, bit3 hsync, bit4 active_video, bit5 active_chroma. A 1 gives active-high; a 0 gives active-low.
- R8: Format word, at address 6: bits 3:0 hold the format and bits 9:8 hold the parity. With format 3, chroma is active only on active lines whose line index parity equals parity bit 0 (0 = even, 1 = odd). When parity bit 1 is set, chroma is also limited to even cycles. With any other format, chroma follows active video.
- R9: Address 16+n holds frame-sync n, with its line in bits 29:16 and its cycle in bits 13:0. `fsync[n]` is high for exactly one cycle per frame, when the counters equal that position.
- R10: Writes go to the shadow set only. An `upd_req` pulse copies the shadow set to the working set at the first frame start after the request edge. A frame start is an edge where the counters wrap from the last cycle of the last line, or any edge while disabled or just being enabled. Other address words use bits 29:16 for the high field and bits 13:0 for the low field:
  - 0: {Vactive, Hactive}
  - 1: {Vtotal, Htotal}
  - 2: {Hsync end, Hsync start}
  - 3: {Vblank end, Vblank start} cycles
  - 4: {Vsync end, Vsync start} lines
  - 5: {Vsync end, Vsync start} cycles
- R11: A shadow write in the same cycle as a commit does not enter the working set. The commit copies the previous shadow contents, and the new write waits for the next update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_en | input | 1 | Run the generator |
| cfg_we | input | 1 | Shadow register write strobe |
| cfg_addr | input | 5 | Shadow register word address |
| cfg_wdata | input | 32 | Shadow register write data |
| upd_req | input | 1 | Request commit of shadow set at next frame start |
| hsync | output | 1 | Horizontal sync |
| hblank | output | 1 | Horizontal blank |
| vsync | output | 1 | Vertical sync |
| vblank | output | 1 | Vertical blank |
| active_video | output | 1 | Active video |
| active_chroma | output | 1 | Active chroma |
| fsync | output | 16 | Per-frame one-cycle position strobes |

## Verification
A shadow write can land on the same edge that commits the shadow set to the working set. The bench provokes this by requesting an update while the generator is disabled, which makes the next edge a commit, and writing a new horizontal sync window on that edge. It then counts the active hsync cycles over a full frame to show that the committed window is the old one. After a second update, it counts again to show the new window. Commit at a running frame boundary is exercised by updates issued mid-frame for polarity and chroma mode, judged against a cycle-by-cycle reference model.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
    localparam int CW  = 14;
    localparam int NFS = 16;
    localparam int AW  = 5;
    localparam int DW  = 32;
    localparam int FSW = $clog2(NFS);
    localparam int HI_LSB = 16;

    typedef logic [CW-1:0] cnt_t;

    localparam int P_VBLANK = 0;
    localparam int P_HBLANK = 1;
    localparam int P_VSYNC  = 2;
    localparam int P_HSYNC  = 3;
    localparam int P_VIDEO  = 4;
    localparam int P_CHROMA = 5;
    localparam int NPOL     = 6;

    localparam logic [AW-2:0] A_ACTIVE = 'd0;
    localparam logic [AW-2:0] A_TOTAL  = 'd1;
    localparam logic [AW-2:0] A_HSYNC  = 'd2;
    localparam logic [AW-2:0] A_VBCYC  = 'd3;
    localparam logic [AW-2:0] A_VSLINE = 'd4;
    localparam logic [AW-2:0] A_VSCYC  = 'd5;
    localparam logic [AW-2:0] A_FMT    = 'd6;
    localparam logic [AW-2:0] A_POL    = 'd7;

    localparam logic [3:0] FMT_ALT_LINE = 4'd3;

    typedef struct packed {
        cnt_t htot;
        cnt_t hact;
        cnt_t vtot;
        cnt_t vact;
        cnt_t hs_start;
        cnt_t hs_end;
        cnt_t vb_start;
        cnt_t vb_end;
        cnt_t vs_lstart;
        cnt_t vs_lend;
        cnt_t vs_cstart;
        cnt_t vs_cend;
        logic [3:0] fmt;
        logic [1:0] cpar;
        logic [NPOL-1:0] pol;
        logic [NFS-1:0][CW-1:0] fs_cyc;
        logic [NFS-1:0][CW-1:0] fs_line;
    } cfg_t;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
    import vtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          upd_req,
    input  logic          frame_start,
    output cfg_t          act_cfg
);
    typedef struct packed {
        cfg_t shd;
        cfg_t act;
        logic pend;
    } regs_st_t;

    regs_st_t st_d, st_q;
    logic commit;
    cnt_t lo_f, hi_f;

    always_comb begin
        st_d   = st_q;
        lo_f   = cfg_wdata[0 +: CW];
        hi_f   = cfg_wdata[HI_LSB +: CW];
        commit = st_q.pend && frame_start;
        if (commit) begin
            st_d.act = st_q.shd;
        end
        st_d.pend = commit ? upd_req : (st_q.pend | upd_req);
        if (cfg_we) begin
            if (cfg_addr[AW-1]) begin
                st_d.shd.fs_cyc[cfg_addr[FSW-1:0]]  = lo_f;
                st_d.shd.fs_line[cfg_addr[FSW-1:0]] = hi_f;
            end else begin
                case (cfg_addr[AW-2:0])
                    A_ACTIVE: begin st_d.shd.hact = lo_f; st_d.shd.vact = hi_f; end
                    A_TOTAL:  begin st_d.shd.htot = lo_f; st_d.shd.vtot = hi_f; end
                    A_HSYNC:  begin st_d.shd.hs_start = lo_f; st_d.shd.hs_end = hi_f; end
                    A_VBCYC:  begin st_d.shd.vb_start = lo_f; st_d.shd.vb_end = hi_f; end
                    A_VSLINE: begin st_d.shd.vs_lstart = lo_f; st_d.shd.vs_lend = hi_f; end
                    A_VSCYC:  begin st_d.shd.vs_cstart = lo_f; st_d.shd.vs_cend = hi_f; end
                    A_FMT:    begin st_d.shd.fmt = cfg_wdata[3:0]; st_d.shd.cpar = cfg_wdata[9:8]; end
                    A_POL:    st_d.shd.pol = cfg_wdata[NPOL-1:0];
                    default:  ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_cfg = st_q.act;

    // R10: a pending request at a frame start loads the shadow contents
    a_r10_commit_copies: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && frame_start) |=> (st_q.act == $past(st_q.shd)));
    // R10 / R11: without a commit the working set does not move
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.pend && frame_start) |=> $stable(st_q.act));
endmodule

// File: rtl/vtg_counter.sv
module vtg_counter
    import vtg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gen_en,
    input  cnt_t htot,
    input  cnt_t vtot,
    output cnt_t h_idx,
    output cnt_t v_idx,
    output logic run,
    output logic frame_start
);
    typedef struct packed {
        cnt_t h;
        cnt_t v;
        logic run;
    } ctr_st_t;

    ctr_st_t st_d, st_q;
    logic [CW:0] h_inc, v_inc;
    logic h_last, v_last;

    always_comb begin
        h_inc       = {1'b0, st_q.h} + 1'b1;
        v_inc       = {1'b0, st_q.v} + 1'b1;
        h_last      = h_inc >= {1'b0, htot};
        v_last      = v_inc >= {1'b0, vtot};
        frame_start = !gen_en || !st_q.run || (h_last && v_last);
        st_d        = st_q;
        if (!gen_en) begin
            st_d = '0;
        end else if (!st_q.run) begin
            st_d.h   = '0;
            st_d.v   = '0;
            st_d.run = 1'b1;
        end else if (h_last) begin
            st_d.h = '0;
            st_d.v = v_last ? '0 : v_inc[CW-1:0];
        end else begin
            st_d.h = h_inc[CW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign h_idx = st_q.h;
    assign v_idx = st_q.v;
    assign run   = st_q.run;

    // R1: disabling parks the counters at the origin
    a_r1_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> (st_q.h == '0 && st_q.v == '0 && !st_q.run));
    // R2: cycle index stays below the line length
    a_r2_h_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && htot != '0) |-> (st_q.h < htot));
    // R2: a line wrap inside the frame moves down exactly one line
    a_r2_line_step: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && st_q.run && h_last && !v_last) |=> (st_q.v == $past(st_q.v) + 1'b1 && st_q.h == '0));
endmodule

// File: rtl/vtg_decode.sv
module vtg_decode
    import vtg_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  cnt_t           h_idx,
    input  cnt_t           v_idx,
    input  logic           run,
    input  cfg_t           cfg,
    output logic           hsync,
    output logic           hblank,
    output logic           vsync,
    output logic           vblank,
    output logic           active_video,
    output logic           active_chroma,
    output logic [NFS-1:0] fsync
);
    function automatic logic reached(cnt_t v, cnt_t h, cnt_t lv, cnt_t lh);
        return (v > lv) || (v == lv && h >= lh);
    endfunction

    logic hs_raw, hb_raw, vs_raw, vb_raw, av_raw, ac_raw;
    logic line_ok, pix_ok;

    always_comb begin
        hs_raw  = (h_idx >= cfg.hs_start) && (h_idx < cfg.hs_end);
        hb_raw  = !(h_idx < cfg.hact);
        av_raw  = (h_idx < cfg.hact) && (v_idx < cfg.vact);
        vs_raw  = reached(v_idx, h_idx, cfg.vs_lstart, cfg.vs_cstart)
               && !reached(v_idx, h_idx, cfg.vs_lend, cfg.vs_cend);
        vb_raw  = reached(v_idx, h_idx, cfg.vact, cfg.vb_start)
               || (v_idx == '0 && h_idx < cfg.vb_end);
        line_ok = (v_idx[0] == cfg.cpar[0]);
        pix_ok  = !cfg.cpar[1] || !h_idx[0];
        ac_raw  = (cfg.fmt == FMT_ALT_LINE) ? (av_raw && line_ok && pix_ok) : av_raw;
    end

    assign hsync         = (run & hs_raw) ^ ~cfg.pol[P_HSYNC];
    assign hblank        = (run & hb_raw) ^ ~cfg.pol[P_HBLANK];
    assign vsync         = (run & vs_raw) ^ ~cfg.pol[P_VSYNC];
    assign vblank        = (run & vb_raw) ^ ~cfg.pol[P_VBLANK];
    assign active_video  = (run & av_raw) ^ ~cfg.pol[P_VIDEO];
    assign active_chroma = (run & ac_raw) ^ ~cfg.pol[P_CHROMA];

    for (genvar i = 0; i < NFS; i++) begin : g_fs
        assign fsync[i] = run && (h_idx == cfg.fs_cyc[i]) && (v_idx == cfg.fs_line[i]);

        // R9: a strobe lasts one cycle unless the frame restarts on it
        a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            (fsync[i] && cfg.htot > 1) |=> (!fsync[i] || (h_idx == '0 && v_idx == '0)));
    end

    // R1: idle generator drives every timing pin to its inactive level
    a_r1_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (hsync == !cfg.pol[P_HSYNC] && vsync == !cfg.pol[P_VSYNC]
                  && active_video == !cfg.pol[P_VIDEO] && fsync == '0));
    // R5: vsync begins only at its programmed line and cycle
    a_r5_vsync_start: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $stable(cfg.vs_lstart) && $stable(cfg.vs_cstart)
         && $stable(cfg.vs_lend) && $stable(cfg.vs_cend) && vs_raw && !$past(vs_raw))
        |-> (v_idx == cfg.vs_lstart && h_idx == cfg.vs_cstart));
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
    import vtg_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           gen_en,
    input  logic           cfg_we,
    input  logic [AW-1:0]  cfg_addr,
    input  logic [DW-1:0]  cfg_wdata,
    input  logic           upd_req,
    output logic           hsync,
    output logic           hblank,
    output logic           vsync,
    output logic           vblank,
    output logic           active_video,
    output logic           active_chroma,
    output logic [NFS-1:0] fsync
);
    cfg_t act_cfg;
    cnt_t h_idx, v_idx;
    logic run, frame_start;

    vtg_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .upd_req     (upd_req),
        .frame_start (frame_start),
        .act_cfg     (act_cfg)
    );

    vtg_counter u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .gen_en      (gen_en),
        .htot        (act_cfg.htot),
        .vtot        (act_cfg.vtot),
        .h_idx       (h_idx),
        .v_idx       (v_idx),
        .run         (run),
        .frame_start (frame_start)
    );

    vtg_decode u_dec (
        .clk           (clk),
        .rst_n         (rst_n),
        .h_idx         (h_idx),
        .v_idx         (v_idx),
        .run           (run),
        .cfg           (act_cfg),
        .hsync         (hsync),
        .hblank        (hblank),
        .vsync         (vsync),
        .vblank        (vblank),
        .active_video  (active_video),
        .active_chroma (active_chroma),
        .fsync         (fsync)
    );
endmodule

// File: tb/tb_vid_timing_gen.sv
module tb_vid_timing_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drv_en = 1'b0, drv_we = 1'b0, drv_upd = 1'b0;
    logic [4:0]  drv_addr = '0;
    logic [31:0] drv_wd = '0;
    logic hsync, hblank, vsync, vblank, active_video, active_chroma;
    logic [15:0] fsync;

    int total = 0;
    int bad = 0;

    // reference model state
    int mh = 0, mv = 0;
    bit mrun = 0, mpend = 0;
    logic [31:0] mshd [32];
    logic [31:0] mact [32];
    int fs_cnt [16];

    always #2.5 clk = ~clk;

    vid_timing_gen dut (
        .clk(clk), .rst_n(rst_n), .gen_en(drv_en), .cfg_we(drv_we),
        .cfg_addr(drv_addr), .cfg_wdata(drv_wd), .upd_req(drv_upd),
        .hsync(hsync), .hblank(hblank), .vsync(vsync), .vblank(vblank),
        .active_video(active_video), .active_chroma(active_chroma), .fsync(fsync)
    );

    function automatic logic [31:0] pk(int hi, int lo);
        return {2'b00, 14'(hi), 2'b00, 14'(lo)};
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        int ht, vt;
        bit last, fstart, commit;
        ht = int'(mact[1][13:0]);
        vt = int'(mact[1][29:16]);
        last   = mrun && (mh + 1 >= ht) && (mv + 1 >= vt);
        fstart = !drv_en || !mrun || last;
        commit = mpend && fstart;
        if (!drv_en) begin mh = 0; mv = 0; mrun = 0; end
        else if (!mrun) begin mh = 0; mv = 0; mrun = 1; end
        else if (mh + 1 >= ht) begin mh = 0; mv = (mv + 1 >= vt) ? 0 : mv + 1; end
        else mh = mh + 1;
        if (commit) for (int i = 0; i < 32; i++) mact[i] = mshd[i];
        mpend = commit ? drv_upd : (mpend | drv_upd);
        if (drv_we && (drv_addr < 8 || drv_addr >= 16)) mshd[drv_addr] = drv_wd;
    endtask

    task automatic compare();
        int ht, ha, va, pos, fmt, par;
        bit r_hs, r_hb, r_vs, r_vb, r_av, r_ac;
        logic [5:0] pv;
        logic [15:0] e_fs;
        ht  = int'(mact[1][13:0]);
        ha  = int'(mact[0][13:0]);
        va  = int'(mact[0][29:16]);
        pv  = mact[7][5:0];
        fmt = int'(mact[6][3:0]);
        par = int'(mact[6][9:8]);
        pos = mv * ht + mh;
        r_hs = mrun && mh >= int'(mact[2][13:0]) && mh < int'(mact[2][29:16]);
        r_hb = mrun && mh >= ha;
        r_av = mrun && mh < ha && mv < va;
        r_vs = mrun && pos >= int'(mact[4][13:0]) * ht + int'(mact[5][13:0])
                    && pos <  int'(mact[4][29:16]) * ht + int'(mact[5][29:16]);
        r_vb = mrun && (pos >= va * ht + int'(mact[3][13:0]) || pos < int'(mact[3][29:16]));
        if (fmt == 3) r_ac = r_av && ((mv % 2) == (par % 2)) && (par < 2 || (mh % 2) == 0);
        else          r_ac = r_av;
        for (int i = 0; i < 16; i++)
            e_fs[i] = mrun && mh == int'(mact[16+i][13:0]) && mv == int'(mact[16+i][29:16]);
        chk(hsync  == (r_hs ? pv[3] : ~pv[3]), "R4/R7 hsync", hsync, r_hs ? pv[3] : ~pv[3]);
        chk(hblank == (r_hb ? pv[1] : ~pv[1]), "R3/R7 hblank", hblank, r_hb ? pv[1] : ~pv[1]);
        chk(active_video == (r_av ? pv[4] : ~pv[4]), "R3/R7 active_video", active_video, r_av ? pv[4] : ~pv[4]);
        chk(vsync  == (r_vs ? pv[2] : ~pv[2]), "R5/R7 vsync", vsync, r_vs ? pv[2] : ~pv[2]);
        chk(vblank == (r_vb ? pv[0] : ~pv[0]), "R6/R7 vblank", vblank, r_vb ? pv[0] : ~pv[0]);
        chk(active_chroma == (r_ac ? pv[5] : ~pv[5]), "R8/R7 active_chroma", active_chroma, r_ac ? pv[5] : ~pv[5]);
        chk(fsync == e_fs, "R9 fsync", fsync, e_fs);
        for (int i = 0; i < 16; i++) if (fsync[i]) fs_cnt[i]++;
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        drv_we  = 1'b0;
        drv_upd = 1'b0;
        compare();
    endtask

    task automatic wr(int a, logic [31:0] d);
        drv_we = 1'b1; drv_addr = 5'(a); drv_wd = d;
        step();
    endtask

    task automatic upd();
        drv_upd = 1'b1;
        step();
    endtask

    task automatic align();
        do step(); while (!(mrun && mh == 0 && mv == 0));
    endtask

    task automatic prog_a(logic [5:0] pol);
        wr(0, pk(4, 6));
        wr(1, pk(6, 10));
        wr(2, pk(9, 7));
        wr(3, pk(3, 7));
        wr(4, pk(5, 4));
        wr(5, pk(5, 2));
        wr(6, 32'h0);
        wr(7, {26'b0, pol});
        for (int i = 0; i < 16; i++) wr(16 + i, pk(i % 6, (i * 3) % 10));
        upd();
    endtask

    task automatic t_reset();
        chk(hsync == 1'b1 && vsync == 1'b1 && hblank == 1'b1, "R1 reset sync/blank idle high", {hsync, vsync, hblank}, 3'b111);
        chk(active_video == 1'b1 && active_chroma == 1'b1 && vblank == 1'b1, "R1 reset video idle high", {active_video, active_chroma, vblank}, 3'b111);
        chk(fsync == 16'h0, "R1 reset fsync low", fsync, 0);
    endtask

    task automatic t_basic();
        prog_a(6'h3F);
        step();
        for (int i = 0; i < 16; i++) fs_cnt[i] = 0;
        drv_en = 1'b1;
        step();
        chk(fsync[0] == 1'b1, "R2 first enabled cycle is line0 cycle0", fsync[0], 1);
        chk(active_video == 1'b1 && hblank == 1'b0, "R3 origin is active", {active_video, hblank}, 2'b10);
        for (int k = 1; k < 120; k++) step();
        for (int i = 0; i < 16; i++)
            chk(fs_cnt[i] == 2, "R9 one strobe per frame", fs_cnt[i], 2);
    endtask

    task automatic t_polarity();
        wr(7, 32'h0);
        upd();
        chk(hsync == 1'b0 || hsync == 1'b1, "R10 pre-commit sample", hsync, hsync);
        align();
        chk(hsync == 1'b1, "R7 hsync active-low idle at cycle 0", hsync, 1);
        chk(active_video == 1'b0, "R7 active_video active-low at origin", active_video, 0);
        for (int k = 0; k < 70; k++) step();
        wr(7, 32'h3F);
        upd();
        align();
        chk(active_video == 1'b1, "R10 polarity restored at frame start", active_video, 1);
    endtask

    task automatic count_chroma(int exp, string tag);
        int n;
        n = active_chroma ? 1 : 0;
        for (int k = 1; k < 60; k++) begin
            step();
            if (active_chroma) n++;
        end
        chk(n == exp, tag, n, exp);
    endtask

    task automatic t_chroma();
        for (int c = 0; c < 4; c++) begin
            wr(6, {22'b0, 2'(c), 4'b0, 4'd3});
            upd();
            align();
            count_chroma((c >= 2) ? 6 : 12, "R8 alternate-line chroma count");
        end
        wr(6, {22'b0, 2'd3, 4'b0, 4'd1});
        upd();
        align();
        count_chroma(24, "R8 chroma follows video for other formats");
    endtask

    task automatic t_disable();
        for (int k = 0; k < 17; k++) step();
        drv_en = 1'b0;
        for (int k = 0; k < 5; k++) step();
        chk(active_video == 1'b0 && hsync == 1'b0, "R1 disabled outputs inactive", {active_video, hsync}, 0);
        chk(fsync == 16'h0, "R1 disabled fsync low", fsync, 0);
        drv_en = 1'b1;
        step();
        chk(fsync[0] == 1'b1, "R2 restart at origin", fsync[0], 1);
    endtask

    task automatic count_hsync(int exp, string tag);
        int n;
        n = hsync ? 1 : 0;
        for (int k = 1; k < 60; k++) begin
            step();
            if (hsync) n++;
        end
        chk(n == exp, tag, n, exp);
    endtask

    task automatic t_collide();
        drv_en = 1'b0;
        step();
        wr(2, pk(4, 2));
        upd();
        wr(2, pk(9, 5));   // lands on the commit edge
        drv_en = 1'b1;
        step();
        count_hsync(12, "R11 commit keeps pre-write shadow");
        upd();
        align();
        count_hsync(24, "R11 later write applied after next update");
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin mshd[i] = '0; mact[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_polarity();
        t_chroma();
        t_disable();
        t_collide();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule